// File: doc/BRIEF.md
# Oscillator Control Register Bank

This block is the register front end for an external crystal oscillator. A processor reaches it over a zero-wait-state APB slave. It keeps three pieces of decoded state: whether the oscillator is switched on, which frequency band is selected, and whether a pause (dormant) is requested. To guard against stray stores, each of these accepts only specific magic codes. Every code that is not recognised falls back to a safe value: an unknown enable code switches the oscillator on, an unknown band code keeps the current band, and an unknown pause code means wake. Every such code also raises a sticky error flag, which software clears by writing a one to it.

The oscillator itself sits outside the block. The block drives an enable output, a pause output and a two-bit band select, and it receives a stability input. That input is synchronised and then reported in the status word. Two neighbouring blocks take their settings from this bank. The startup timer receives a 14-bit delay and a times-four flag. The pause counter receives an 8-bit load value with a one-cycle load strobe, and its live count is read back through this bank.

Top module: `oscctl_regbank`

## Requirements
- R1: After reset the oscillator is disabled, no pause is requested, the band index is 0 and the error flag is clear. Control reads 0x00D1EAA0, pause reads 0x77616B65, status reads 0 while the stability input is low, and the startup word reads 0.
- R2: A write to control offset 0x00 takes the enable code from bits 23:12. Code 0xD1E turns the oscillator off and code 0xFAB turns it on. Any other code turns it on and sets the error flag. Control readback bits 23:12 show 0xFAB when on and 0xD1E when off.
- R3: The same control write takes the band code from bits 11:0. Codes 0xAA0 to 0xAA3 select band index code[1:0] on the band output. Any other code leaves the band unchanged and sets the error flag. Control readback bits 11:0 show 0xAA0 plus the index.
- R4: A 32-bit write to pause offset 0x08 requests a pause for 0x636F6D61 and wake for 0x77616B65. Any other value selects wake and sets the error flag. Readback returns whichever of the two codes is in effect.
- R5: The error flag reads at status bit 24. Writing status offset 0x04 with bit 24 set clears it, and writing with bit 24 clear leaves it unchanged. If a set and a clear land in the same cycle, the set wins.
- R6: Status bit 12 mirrors the enable state. Status bit 31 reports the stability input, delayed by SYNC_STAGES clock cycles. Status bits 1:0 always read 0.
- R7: Startup offset 0x0C stores a delay in bits 13:0 and a times-four flag in bit 20. Both drive outputs and read back in place, with all other bits reading 0.
- R8: A write to count offset 0x1C pulses the load strobe for exactly one cycle, with pwdata[7:0] on the load value. A read of 0x1C returns the external count in bits 7:0.
- R9: Reads of any other address return 0, and writes to them change no state. pready is always 1 and pslverr is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and register clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Always zero |
| osc_stable_i | input | 1 | Oscillator running and stable (asynchronous) |
| osc_enable_o | output | 1 | Oscillator enable |
| osc_pause_o | output | 1 | Dormant request |
| band_sel_o | output | 2 | Selected frequency band index |
| startup_delay_o | output | 14 | Startup timer delay |
| startup_x4_o | output | 1 | Startup delay times-four |
| pause_load_val_o | output | 8 | Pause counter load value |
| pause_load_o | output | 1 | Pause counter load strobe |
| pause_count_i | input | 8 | Live pause counter value |

## Verification
All 4096 enable codes are written in turn. Each one is followed by a check of the enable output and the error flag, which separates the two valid codes from the fallback path. Band codes are swept from 0xA00 to 0xAFF against a running model of the last valid band, which shows whether an invalid code really holds the band or disturbs it. Valid, near-miss and garbage pause words show the difference between a real pause request and the wake fallback. An address sweep over every word offset confirms that unmapped reads return zero and that unmapped writes leave the stored state untouched.

// File: rtl/oscctl_pkg.sv
package oscctl_pkg;
  localparam int unsigned DATA_W = 32;

  localparam logic [7:0] OFS_CTRL    = 8'h00;
  localparam logic [7:0] OFS_STATUS  = 8'h04;
  localparam logic [7:0] OFS_PAUSE   = 8'h08;
  localparam logic [7:0] OFS_STARTUP = 8'h0C;
  localparam logic [7:0] OFS_COUNT   = 8'h1C;

  localparam logic [11:0] EN_OFF_CODE = 12'hD1E;
  localparam logic [11:0] EN_ON_CODE  = 12'hFAB;
  localparam logic [11:0] BAND_BASE   = 12'hAA0;
  localparam logic [31:0] SLEEP_CODE  = 32'h636F6D61;
  localparam logic [31:0] WAKE_CODE   = 32'h77616B65;

  localparam int unsigned BIT_BAD    = 24;
  localparam int unsigned BIT_ON     = 12;
  localparam int unsigned BIT_STABLE = 31;

  typedef enum logic [2:0] {
    SEL_CTRL    = 3'd0,
    SEL_STATUS  = 3'd1,
    SEL_PAUSE   = 3'd2,
    SEL_STARTUP = 3'd3,
    SEL_COUNT   = 3'd4,
    SEL_NONE    = 3'd7
  } reg_sel_e;

  localparam int unsigned NUM_REGS = 5;
endpackage

// File: rtl/oscctl_decode.sv
module oscctl_decode
  import oscctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output reg_sel_e          rd_sel,
  output logic [NUM_REGS-1:0] wr_stb
);
  localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_PAUSE   = ADDR_W'(OFS_PAUSE);
  localparam logic [ADDR_W-1:0] A_STARTUP = ADDR_W'(OFS_STARTUP);
  localparam logic [ADDR_W-1:0] A_COUNT   = ADDR_W'(OFS_COUNT);

  logic access_wr;

  always_comb begin
    unique case (paddr)
      A_CTRL:    rd_sel = SEL_CTRL;
      A_STATUS:  rd_sel = SEL_STATUS;
      A_PAUSE:   rd_sel = SEL_PAUSE;
      A_STARTUP: rd_sel = SEL_STARTUP;
      A_COUNT:   rd_sel = SEL_COUNT;
      default:   rd_sel = SEL_NONE;
    endcase
  end

  assign access_wr = psel & penable & pwrite;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_wstb
    assign wr_stb[g] = access_wr && (rd_sel == reg_sel_e'(g));
  end

  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb)) else $error("write strobes not one-hot"); // R9
  AST_WR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_stb) |-> (psel && penable && pwrite)) else $error("write outside access"); // R9
endmodule

// File: rtl/oscctl_core.sv
module oscctl_core
  import oscctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_status,
  input  logic              wr_pause,
  input  logic [DATA_W-1:0] wdata,
  output logic              en_q,
  output logic              pause_q,
  output logic [1:0]        band_q,
  output logic              bad_q
);
  logic [11:0] en_code;
  logic [11:0] band_code;
  logic        en_invalid;
  logic        band_valid;
  logic        pause_invalid;
  logic        bad_set;
  logic        bad_clr;
  logic        en_d;
  logic        pause_d;
  logic [1:0]  band_d;
  logic        bad_d;
  logic        band_ce;
  logic        bad_ce;

  assign en_code   = wdata[23:12];
  assign band_code = wdata[11:0];

  always_comb begin
    en_invalid    = (en_code != EN_ON_CODE) && (en_code != EN_OFF_CODE);
    band_valid    = (band_code[11:2] == BAND_BASE[11:2]);
    pause_invalid = (wdata != SLEEP_CODE) && (wdata != WAKE_CODE);
    bad_set       = (wr_ctrl && (en_invalid || !band_valid)) ||
                    (wr_pause && pause_invalid);
    bad_clr       = wr_status && wdata[BIT_BAD];
  end

  always_comb begin
    en_d    = (en_code != EN_OFF_CODE);
    pause_d = (wdata == SLEEP_CODE);
    band_d  = band_code[1:0];
    band_ce = wr_ctrl && band_valid;
    bad_ce  = bad_set || bad_clr;
    bad_d   = bad_set ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      pause_q <= 1'b0;
      band_q  <= 2'd0;
      bad_q   <= 1'b0;
    end else begin
      if (wr_ctrl)  en_q    <= en_d;
      if (wr_pause) pause_q <= pause_d;
      if (band_ce)  band_q  <= band_d;
      if (bad_ce)   bad_q   <= bad_d;
    end
  end

  AST_OFF_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata[23:12] == EN_OFF_CODE) |=> !en_q) else $error("off code"); // R2
  AST_BAD_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata[23:12] != EN_OFF_CODE && wdata[23:12] != EN_ON_CODE) |=> (en_q && bad_q))
    else $error("bad enable fallback"); // R2
  AST_BAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata[11:2] != BAND_BASE[11:2]) |=> $stable(band_q)) else $error("band hold"); // R3
  AST_PAUSE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pause && wdata != SLEEP_CODE) |=> !pause_q) else $error("pause fallback"); // R4
  AST_BAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_q && !(wr_status && wdata[BIT_BAD])) |=> bad_q) else $error("flag lost"); // R5
  AST_BAD_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pause && wdata != SLEEP_CODE && wdata != WAKE_CODE) |=> bad_q) else $error("set lost"); // R5
endmodule

// File: rtl/oscctl_aux.sv
module oscctl_aux
  import oscctl_pkg::*;
#(
  parameter int unsigned DELAY_W     = 14,
  parameter int unsigned COUNT_W     = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_startup,
  input  logic               wr_count,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               stable_async,
  output logic [DELAY_W-1:0] delay_q,
  output logic               x4_q,
  output logic [COUNT_W-1:0] load_val_q,
  output logic               load_q,
  output logic               stable_sync
);
  localparam int unsigned X4_BIT = 20;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], stable_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      delay_q    <= '0;
      x4_q       <= 1'b0;
      load_val_q <= '0;
      load_q     <= 1'b0;
      sync_q     <= '0;
    end else begin
      if (wr_startup) begin
        delay_q <= wdata[DELAY_W-1:0];
        x4_q    <= wdata[X4_BIT];
      end
      if (wr_count) load_val_q <= wdata[COUNT_W-1:0];
      load_q <= wr_count;
      sync_q <= sync_d;
    end
  end

  assign stable_sync = sync_q[SYNC_STAGES-1];

  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |=> !load_q) else $error("load strobe too long"); // R8
  AST_LOAD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_count |=> (load_q && load_val_q == $past(wdata[COUNT_W-1:0]))) else $error("load value"); // R8
  AST_STARTUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_startup |=> ($stable(delay_q) && $stable(x4_q))) else $error("startup changed"); // R7
endmodule

// File: rtl/oscctl_regbank.sv
module oscctl_regbank
  import oscctl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned DELAY_W     = 14,
  parameter int unsigned COUNT_W     = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               pclk,
  input  logic               presetn,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [ADDR_W-1:0]  paddr,
  input  logic [31:0]        pwdata,
  output logic [31:0]        prdata,
  output logic               pready,
  output logic               pslverr,
  input  logic               osc_stable_i,
  output logic               osc_enable_o,
  output logic               osc_pause_o,
  output logic [1:0]         band_sel_o,
  output logic [DELAY_W-1:0] startup_delay_o,
  output logic               startup_x4_o,
  output logic [COUNT_W-1:0] pause_load_val_o,
  output logic               pause_load_o,
  input  logic [COUNT_W-1:0] pause_count_i
);
  logic rst_meta_q;
  logic rst_n_q;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      rst_meta_q <= 1'b0;
      rst_n_q    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_q    <= rst_meta_q;
    end
  end

  reg_sel_e            rd_sel;
  logic [NUM_REGS-1:0] wr_stb;
  logic                en_q;
  logic                pause_q;
  logic [1:0]          band_q;
  logic                bad_q;
  logic                stable_sync;

  oscctl_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk     (pclk),
    .rst_n   (rst_n_q),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .rd_sel  (rd_sel),
    .wr_stb  (wr_stb)
  );

  oscctl_core u_core (
    .clk       (pclk),
    .rst_n     (rst_n_q),
    .wr_ctrl   (wr_stb[SEL_CTRL]),
    .wr_status (wr_stb[SEL_STATUS]),
    .wr_pause  (wr_stb[SEL_PAUSE]),
    .wdata     (pwdata),
    .en_q      (en_q),
    .pause_q   (pause_q),
    .band_q    (band_q),
    .bad_q     (bad_q)
  );

  oscctl_aux #(
    .DELAY_W     (DELAY_W),
    .COUNT_W     (COUNT_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_aux (
    .clk          (pclk),
    .rst_n        (rst_n_q),
    .wr_startup   (wr_stb[SEL_STARTUP]),
    .wr_count     (wr_stb[SEL_COUNT]),
    .wdata        (pwdata),
    .stable_async (osc_stable_i),
    .delay_q      (startup_delay_o),
    .x4_q         (startup_x4_o),
    .load_val_q   (pause_load_val_o),
    .load_q       (pause_load_o),
    .stable_sync  (stable_sync)
  );

  always_comb begin
    prdata = '0;
    if (psel) begin
      unique case (rd_sel)
        SEL_CTRL: begin
          prdata[23:12] = en_q ? EN_ON_CODE : EN_OFF_CODE;
          prdata[11:0]  = {BAND_BASE[11:2], band_q};
        end
        SEL_STATUS: begin
          prdata[BIT_STABLE] = stable_sync;
          prdata[BIT_BAD]    = bad_q;
          prdata[BIT_ON]     = en_q;
        end
        SEL_PAUSE:   prdata = pause_q ? SLEEP_CODE : WAKE_CODE;
        SEL_STARTUP: begin
          prdata[DELAY_W-1:0] = startup_delay_o;
          prdata[20]          = startup_x4_o;
        end
        SEL_COUNT:   prdata[COUNT_W-1:0] = pause_count_i;
        default:     prdata = '0;
      endcase
    end
  end

  assign osc_enable_o = en_q;
  assign osc_pause_o  = pause_q;
  assign band_sel_o   = band_q;
  assign pready       = 1'b1;
  assign pslverr      = 1'b0;

  AST_UNMAPPED_ZERO: assert property (@(posedge pclk) disable iff (!rst_n_q)
    (psel && rd_sel == SEL_NONE) |-> (prdata == '0)) else $error("unmapped read"); // R9
  AST_STATUS_LOW_ZERO: assert property (@(posedge pclk) disable iff (!rst_n_q)
    (psel && rd_sel == SEL_STATUS) |-> (prdata[1:0] == 2'b00)) else $error("status band bits"); // R6
endmodule

// File: tb/sim_oscctl_regbank.sv
module sim_oscctl_regbank;
  localparam int CLK_PERIOD = 10;

  logic        pclk;
  logic        presetn;
  logic        psel;
  logic        penable;
  logic        pwrite;
  logic [4:0]  paddr;
  logic [31:0] pwdata;
  logic [31:0] prdata;
  logic        pready;
  logic        pslverr;
  logic        osc_stable_i;
  logic        osc_enable_o;
  logic        osc_pause_o;
  logic [1:0]  band_sel_o;
  logic [13:0] startup_delay_o;
  logic        startup_x4_o;
  logic [7:0]  pause_load_val_o;
  logic        pause_load_o;
  logic [7:0]  pause_count_i;

  int n_chk;
  int n_fail;
  bit done;

  oscctl_regbank u0 (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .osc_stable_i(osc_stable_i),
    .osc_enable_o(osc_enable_o), .osc_pause_o(osc_pause_o),
    .band_sel_o(band_sel_o), .startup_delay_o(startup_delay_o),
    .startup_x4_o(startup_x4_o), .pause_load_val_o(pause_load_val_o),
    .pause_load_o(pause_load_o), .pause_count_i(pause_count_i)
  );

  initial begin
    pclk = 1'b0;
    forever #(CLK_PERIOD/2) pclk = ~pclk;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    @(negedge pclk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge pclk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    logic [31:0] rd;
    logic [1:0]  band_m;
    logic [11:0] en_code;
    n_chk = 0; n_fail = 0; done = 1'b0;
    psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
    osc_stable_i = 0; pause_count_i = 8'h00;
    presetn = 1'b0;
    repeat (3) @(negedge pclk);
    presetn = 1'b1;
    repeat (4) @(negedge pclk);

    // R1 reset state
    check("R1 enable", {31'd0, osc_enable_o}, 32'd0);
    check("R1 pause", {31'd0, osc_pause_o}, 32'd0);
    check("R1 band", {30'd0, band_sel_o}, 32'd0);
    apb_rd(5'h00, rd); check("R1 ctrl", rd, 32'h00D1EAA0);
    apb_rd(5'h04, rd); check("R1 status", rd, 32'h0);
    apb_rd(5'h08, rd); check("R1 pause rd", rd, 32'h77616B65);
    apb_rd(5'h0C, rd); check("R1 startup", rd, 32'h0);
    check("R9 pready", {31'd0, pready}, 32'd1);
    check("R9 pslverr", {31'd0, pslverr}, 32'd0);

    // R2 exhaustive enable sweep, valid band 0xAA0
    for (int c = 0; c < 4096; c++) begin
      en_code = 12'(c);
      apb_wr(5'h00, {8'h00, en_code, 12'hAA0});
      check("R2 enable out", {31'd0, osc_enable_o}, {31'd0, en_code != 12'hD1E});
      apb_rd(5'h04, rd);
      check("R2 bad flag", {31'd0, rd[24]},
            {31'd0, (en_code != 12'hD1E) && (en_code != 12'hFAB)});
      check("R6 on bit", {31'd0, rd[12]}, {31'd0, en_code != 12'hD1E});
      if (rd[24]) apb_wr(5'h04, 32'h0100_0000);
    end
    apb_rd(5'h04, rd); check("R5 cleared", {31'd0, rd[24]}, 32'd0);

    // R3 band sweep with running model
    band_m = 2'd0;
    for (int c = 12'hA00; c < 12'hB00; c++) begin
      apb_wr(5'h00, {8'h00, 12'hFAB, 12'(c)});
      if (c[11:2] == 10'h2A8) band_m = c[1:0];
      check("R3 band out", {30'd0, band_sel_o}, {30'd0, band_m});
      apb_rd(5'h00, rd);
      check("R3 ctrl rd", rd, {8'h00, 12'hFAB, 10'h2A8, band_m});
      apb_rd(5'h04, rd);
      check("R3 bad flag", {31'd0, rd[24]}, {31'd0, c[11:2] != 10'h2A8});
      check("R6 band bits zero", {30'd0, rd[1:0]}, 32'd0);
      if (rd[24]) apb_wr(5'h04, 32'h0100_0000);
    end

    // R5 write-zero keeps the flag, write-one clears
    apb_wr(5'h00, 32'h00123AA1);
    apb_wr(5'h04, 32'hFEFF_FFFF);
    apb_rd(5'h04, rd); check("R5 kept", {31'd0, rd[24]}, 32'd1);
    apb_wr(5'h04, 32'h0100_0000);
    apb_rd(5'h04, rd); check("R5 clear", {31'd0, rd[24]}, 32'd0);

    // R4 pause codes
    apb_wr(5'h08, 32'h636F6D61);
    check("R4 sleep", {31'd0, osc_pause_o}, 32'd1);
    apb_rd(5'h08, rd); check("R4 sleep rd", rd, 32'h636F6D61);
    apb_rd(5'h04, rd); check("R4 no bad", {31'd0, rd[24]}, 32'd0);
    apb_wr(5'h08, 32'h77616B65);
    check("R4 wake", {31'd0, osc_pause_o}, 32'd0);
    apb_wr(5'h08, 32'h636F6D61);
    apb_wr(5'h08, 32'h636F6D60);
    check("R4 near miss wakes", {31'd0, osc_pause_o}, 32'd0);
    apb_rd(5'h08, rd); check("R4 near miss rd", rd, 32'h77616B65);
    apb_rd(5'h04, rd); check("R4 bad set", {31'd0, rd[24]}, 32'd1);
    apb_wr(5'h04, 32'h0100_0000);
    apb_wr(5'h08, 32'h0);
    apb_rd(5'h04, rd); check("R4 zero bad", {31'd0, rd[24]}, 32'd1);
    apb_wr(5'h04, 32'h0100_0000);

    // R6 stability input through synchroniser
    osc_stable_i = 1'b1;
    repeat (4) @(negedge pclk);
    apb_rd(5'h04, rd); check("R6 stable", {31'd0, rd[31]}, 32'd1);
    osc_stable_i = 1'b0;
    repeat (4) @(negedge pclk);
    apb_rd(5'h04, rd); check("R6 unstable", {31'd0, rd[31]}, 32'd0);

    // R7 startup fields
    apb_wr(5'h0C, 32'hFFFF_FFFF);
    check("R7 delay", {18'd0, startup_delay_o}, 32'h3FFF);
    check("R7 x4", {31'd0, startup_x4_o}, 32'd1);
    apb_rd(5'h0C, rd); check("R7 rd", rd, 32'h0010_3FFF);
    apb_wr(5'h0C, 32'h0000_00C4);
    apb_rd(5'h0C, rd); check("R7 rd2", rd, 32'h0000_00C4);

    // R8 pause count load
    apb_wr(5'h1C, 32'hABCD_EF5A);
    check("R8 load strobe", {31'd0, pause_load_o}, 32'd1);
    check("R8 load val", {24'd0, pause_load_val_o}, 32'h5A);
    @(negedge pclk);
    check("R8 strobe single", {31'd0, pause_load_o}, 32'd0);
    pause_count_i = 8'h3C;
    apb_rd(5'h1C, rd); check("R8 count rd", rd, 32'h3C);

    // R9 unmapped sweep: reads zero, writes ignored
    apb_wr(5'h00, 32'h00FABAA2);
    for (int a = 0; a < 32; a++) begin
      if (a != 0 && a != 4 && a != 8 && a != 12 && a != 28) begin
        apb_wr(5'(a), 32'h00D1EAA1);
        check("R9 no strobe", {31'd0, pause_load_o}, 32'd0);
        apb_rd(5'(a), rd); check("R9 unmapped rd", rd, 32'h0);
      end
    end
    apb_rd(5'h00, rd); check("R9 ctrl intact", rd, 32'h00FABAA2);
    apb_rd(5'h04, rd); check("R9 no bad", {31'd0, rd[24]}, 32'd0);
    apb_rd(5'h0C, rd); check("R9 startup intact", rd, 32'h0000_00C4);

    done = 1'b1;
    summary();
  end
endmodule